// File: doc/BRIEF.md
# TLB PID Flush Scanner

This block walks every entry of a translation buffer for one process and, for each entry that belongs to that process, issues a page-invalidate request downstream. It is started with a process identifier. It then reads the entries one at a time through a read port into the entry storage. It checks each entry's valid bit, its global bit and its owner tag. For each matching entry it presents the entry's virtual page as a byte address on a valid/ready stream.

The storage holds two arrays, one for instruction translations and one for data translations. Each array has 4 ways of 16 indices, so one walk covers 128 entries. The block never writes the storage. Global entries are shared by all processes, so they are always passed over. A downstream agent that flushes cached translations consumes the stream. The read port is asynchronous: the entry data must be valid in the same cycle as the read address.

Top module: `tlb_flush_scanner`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `inv_valid_o` are low.
- R2: A start pulse while idle latches bits 7:0 of `pid_i` as the process tag for the walk. Bits 31:8 are ignored.
- R3: The flat entry number is `{rd_arr_o, rd_way_o, rd_idx_o}`, with the array in bit 6, the way in bits 5:4 and the index in bits 3:0. Entries are visited in increasing flat order: 0 (array 0, way 0, index 0) through 127, with the index innermost. The walk starts at entry 0 in the first busy cycle.
- R4: An entry qualifies only when all of the following hold: `rd_lo_i[3]` (valid) is 1, `rd_lo_i[4]` (global) is 0, and `rd_hi_i[7:0]` equals the latched tag.
- R5: The request address of a qualifying entry is `{rd_hi_i[31:13], 13'b0}`.
- R6: Each busy cycle that is not stalled advances the walk by exactly one entry. A walk with no stalls keeps `busy_o` high for exactly 128 cycles.
- R7: When the current entry qualifies while an earlier request is still unaccepted (`inv_valid_o` high, `inv_ready_i` low), the read address holds in the next cycle.
- R8: While `inv_valid_o` is high and `inv_ready_i` is low, the next cycle keeps `inv_valid_o` high with `inv_addr_o` unchanged.
- R9: `done_o` is high for exactly one cycle: the cycle after the last entry is advanced past, in which `busy_o` has just fallen. The last request may still be pending then.
- R10: A start pulse received while busy is ignored: the walk neither restarts nor takes the new tag.
- R11: The accepted requests form exactly the list of qualifying entries, in walk order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (used only when idle) |
| pid_i | input | 32 | Process tag; only bits 7:0 are used |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse at the end of the walk |
| rd_arr_o | output | 1 | Read address: array (0 instruction, 1 data) |
| rd_way_o | output | 2 | Read address: way |
| rd_idx_o | output | 4 | Read address: index |
| rd_lo_i | input | 32 | Entry low word (bit 4 global, bit 3 valid) |
| rd_hi_i | input | 32 | Entry high word (31:13 page, 7:0 tag) |
| inv_valid_o | output | 1 | Invalidate request valid |
| inv_ready_i | input | 1 | Invalidate request accepted |
| inv_addr_o | output | 32 | Page byte address to invalidate |

## Verification
The storage is filled with pseudo-random entries from several seeds. The owner tags are skewed toward the requested tag so that matches, invalid entries and global entries are all mixed. The consumer runs in three patterns: always ready, ready every other cycle, and ready one cycle in four. The always-ready runs pin down the visit order and the exact walk length. The throttled runs separate correct stalling from dropped or duplicated requests, because the ordered address list must still match the reference. Directed cases put upper bits on the tag, fill the storage with global entries, and pulse start in the middle of a walk. These cases separate tag masking, global exclusion and restart protection from the plain match logic.

// File: rtl/tlb_flush_pkg.sv
package tlb_flush_pkg;
  // entry word field positions decoded by the scanner
  localparam int unsigned LO_VALID_BIT  = 3;
  localparam int unsigned LO_GLOBAL_BIT = 4;
endpackage

// File: rtl/tlb_flush_walker.sv
module tlb_flush_walker #(
  parameter int unsigned NUM_ENT = 128,
  localparam int unsigned ENT_W  = $clog2(NUM_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  output logic             launch_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ENT_W-1:0] ent_o
);
  logic             busy_q, done_q;
  logic [ENT_W-1:0] ent_q;
  logic             last;

  assign last     = ent_q == ENT_W'(NUM_ENT - 1);
  assign launch_o = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ent_q  <= '0;
    end else begin
      done_q <= busy_q && adv_i && last;
      if (launch_o) begin
        busy_q <= 1'b1;
        ent_q  <= '0;
      end else if (busy_q && adv_i) begin
        if (last) busy_q <= 1'b0;
        else      ent_q  <= ent_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign ent_o  = ent_q;

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r9_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !last |=> busy_q && (ent_q == $past(ent_q) + ENT_W'($past(adv_i))));
endmodule

// File: rtl/tlb_flush_match.sv
module tlb_flush_match #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned PAGE_SHIFT = 13
) (
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic [PID_W-1:0]  pid_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] addr_o
);
  import tlb_flush_pkg::*;

  assign hit_o  = lo_i[LO_VALID_BIT] && !lo_i[LO_GLOBAL_BIT] && (hi_i[PID_W-1:0] == pid_i);
  assign addr_o = {hi_i[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

  logic unused_fields;
  assign unused_fields = ^{lo_i, hi_i[PAGE_SHIFT-1:PID_W]};
endmodule

// File: rtl/tlb_flush_out.sv
module tlb_flush_out #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned PAGE_SHIFT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] addr_o
);
  logic              valid_q;
  logic [WORD_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ready_i |=> valid_q && $stable(addr_q));
  a_r5_page_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> addr_q[PAGE_SHIFT-1:0] == '0);
endmodule

// File: rtl/tlb_flush_scanner.sv
module tlb_flush_scanner #(
  parameter int unsigned NUM_ARR    = 2,
  parameter int unsigned NUM_WAY    = 4,
  parameter int unsigned NUM_IDX    = 16,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned PAGE_SHIFT = 13,
  localparam int unsigned ARR_W     = $clog2(NUM_ARR),
  localparam int unsigned WAY_W     = $clog2(NUM_WAY),
  localparam int unsigned IDX_W     = $clog2(NUM_IDX),
  localparam int unsigned NUM_ENT   = NUM_ARR * NUM_WAY * NUM_IDX,
  localparam int unsigned ENT_W     = ARR_W + WAY_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] pid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ARR_W-1:0]  rd_arr_o,
  output logic [WAY_W-1:0]  rd_way_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [WORD_W-1:0] rd_lo_i,
  input  logic [WORD_W-1:0] rd_hi_i,
  output logic              inv_valid_o,
  input  logic              inv_ready_i,
  output logic [WORD_W-1:0] inv_addr_o
);
  logic             launch, busy, adv, hit, load, stall;
  logic [ENT_W-1:0] ent;
  logic [PID_W-1:0] pid_q;
  logic [WORD_W-1:0] page_addr;

  // only the low tag bits take part in the match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pid_q <= '0;
    else if (launch) pid_q <= pid_i[PID_W-1:0];
  end

  tlb_flush_walker #(.NUM_ENT(NUM_ENT)) i_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .adv_i   (adv),
    .launch_o(launch),
    .busy_o  (busy),
    .done_o  (done_o),
    .ent_o   (ent)
  );

  tlb_flush_match #(.WORD_W(WORD_W), .PID_W(PID_W), .PAGE_SHIFT(PAGE_SHIFT)) i_match (
    .lo_i  (rd_lo_i),
    .hi_i  (rd_hi_i),
    .pid_i (pid_q),
    .hit_o (hit),
    .addr_o(page_addr)
  );

  assign stall = hit && inv_valid_o && !inv_ready_i;
  assign adv   = !stall;
  assign load  = busy && hit && !stall;

  tlb_flush_out #(.WORD_W(WORD_W), .PAGE_SHIFT(PAGE_SHIFT)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (page_addr),
    .ready_i(inv_ready_i),
    .valid_o(inv_valid_o),
    .addr_o (inv_addr_o)
  );

  assign busy_o   = busy;
  assign rd_idx_o = ent[IDX_W-1:0];
  assign rd_way_o = ent[IDX_W +: WAY_W];
  assign rd_arr_o = ent[IDX_W+WAY_W +: ARR_W];

  a_r7_stall_holds_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && hit && inv_valid_o && !inv_ready_i |=> $stable(ent));
  a_r6_walk_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !hit && !launch && ent != ENT_W'(NUM_ENT - 1) |=> ent == $past(ent) + 1'b1);
  a_r10_pid_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(pid_q));
endmodule

// File: tb/test_tlb_flush_scanner.sv
module test_tlb_flush_scanner;
  localparam int NENT = 128;

  typedef struct packed {
    logic [31:0] pid;
    logic [31:0] seed;
    logic [1:0]  mode;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0000_0012, 32'h0000_0001, 2'd0},
    '{32'hABCD_FF5A, 32'h0000_0077, 2'd0},
    '{32'h0000_0003, 32'h0000_1234, 2'd1},
    '{32'h0000_0080, 32'h0000_BEEF, 2'd2},
    '{32'hFFFF_FFFF, 32'h0000_55AA, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] pid_i = '0;
  logic        busy_o, done_o, inv_valid_o;
  logic        inv_ready_i = 1'b0;
  logic [0:0]  rd_arr_o;
  logic [1:0]  rd_way_o;
  logic [3:0]  rd_idx_o;
  logic [31:0] rd_lo_i, rd_hi_i, inv_addr_o;

  logic [31:0] mem_lo [NENT];
  logic [31:0] mem_hi [NENT];
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign rd_lo_i = mem_lo[{rd_arr_o, rd_way_o, rd_idx_o}];
  assign rd_hi_i = mem_hi[{rd_arr_o, rd_way_o, rd_idx_o}];

  tlb_flush_scanner i_tlb_flush_scanner (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pid_i(pid_i),
    .busy_o(busy_o), .done_o(done_o),
    .rd_arr_o(rd_arr_o), .rd_way_o(rd_way_o), .rd_idx_o(rd_idx_o),
    .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
    .inv_valid_o(inv_valid_o), .inv_ready_i(inv_ready_i), .inv_addr_o(inv_addr_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: act %0d cycles exp < 150000", cycles);
      errors = errors + 1;
      checks = checks + 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lcg(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic bit qual(input int e, input logic [7:0] p);
    return mem_lo[e][3] && !mem_lo[e][4] && mem_hi[e][7:0] == p;
  endfunction

  task automatic fill(input logic [31:0] seed, input logic [7:0] p);
    logic [31:0] s = seed;
    for (int e = 0; e < NENT; e++) begin
      s = lcg(s);
      mem_hi[e] = {s[31:13], 5'(s[4:0]), (s[7:5] < 3'd3) ? p : s[15:8]};
      s = lcg(s);
      mem_lo[e] = s;
    end
  endtask

  task automatic run_scan(input logic [31:0] pid_in, input int mode, input int restart_at,
                          input logic [31:0] restart_pid, input string tag);
    int busy_cnt = 0, done_cnt = 0, order_err = 0, stall_err = 0, hold_err = 0, cyc = 0;
    bit exp_stall = 0, exp_hold = 0;
    logic [6:0] prev_ent = '0;
    logic [31:0] prev_addr = '0;
    exp_q.delete();
    got_q.delete();
    for (int e = 0; e < NENT; e++)
      if (qual(e, pid_in[7:0])) exp_q.push_back({mem_hi[e][31:13], 13'b0});
    @(negedge clk);
    start_i = 1'b1;
    pid_i   = pid_in;
    @(negedge clk);
    start_i = 1'b0;
    while (cyc < 4000) begin
      inv_ready_i = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : (cyc % 4 == 3);
      if (exp_stall && {rd_arr_o, rd_way_o, rd_idx_o} != prev_ent) stall_err++;
      if (exp_hold && (!inv_valid_o || inv_addr_o != prev_addr)) hold_err++;
      prev_ent  = {rd_arr_o, rd_way_o, rd_idx_o};
      prev_addr = inv_addr_o;
      exp_hold  = inv_valid_o && !inv_ready_i;
      exp_stall = busy_o && exp_hold && qual(int'(prev_ent), pid_in[7:0]);
      if (busy_o) begin
        if (mode == 0 && prev_ent != busy_cnt[6:0]) order_err++;
        busy_cnt++;
      end
      if (done_o) done_cnt++;
      if (inv_valid_o && inv_ready_i) got_q.push_back(inv_addr_o);
      start_i = (cyc == restart_at);
      if (cyc == restart_at) pid_i = restart_pid;
      if (done_cnt > 0 && !busy_o && !inv_valid_o) break;
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    inv_ready_i = 1'b0;
    check(cyc < 4000, {tag, " R9 walk ends"}, cyc, 4000);
    check(got_q.size() == exp_q.size(), {tag, " R4 R11 count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], {tag, " R5 R11 addr"}, got_q[i], exp_q[i]);
    check(done_cnt == 1, {tag, " R9 done pulse"}, done_cnt, 1);
    check(stall_err == 0, {tag, " R7 stall"}, stall_err, 0);
    check(hold_err == 0, {tag, " R8 hold"}, hold_err, 0);
    if (mode == 0) begin
      check(busy_cnt == NENT, {tag, " R6 busy length"}, busy_cnt, NENT);
      check(order_err == 0, {tag, " R3 visit order"}, order_err, 0);
    end
  endtask

  initial begin
    for (int e = 0; e < NENT; e++) begin
      mem_lo[e] = '0;
      mem_hi[e] = '0;
    end
    #1;
    check(!busy_o && !done_o && !inv_valid_o, "R1 in reset", {busy_o, done_o, inv_valid_o}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !inv_valid_o, "R1 after reset", {busy_o, done_o, inv_valid_o}, 0);

    foreach (VECS[v]) begin
      fill(VECS[v].seed, VECS[v].pid[7:0]);
      run_scan(VECS[v].pid, int'(VECS[v].mode), -1, '0, (v == 1) ? "R2 vec" : "vec");
    end

    // R10: start mid-walk with another tag must not restart or retag
    fill(32'h0000_0F0F, 8'h12);
    run_scan(32'h12, 0, 20, 32'h34, "R10 restart");

    // R4: global and invalid entries never qualify
    for (int e = 0; e < NENT; e++) begin
      mem_hi[e] = {19'(e + 100), 5'd0, 8'h21};
      mem_lo[e] = 32'h18;
    end
    mem_lo[37] = 32'h08;
    mem_lo[90] = 32'h00;
    run_scan(32'h21, 1, -1, '0, "R4 global");
    check(got_q.size() == 1, "R4 only one non-global", got_q.size(), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule